// File: doc/BRIEF.md
# Vectored Interrupt Entry and Return Sequencer

This block sits beside a 16-bit processor core and takes over its program counter, stack pointer and status register whenever control must be redirected. At each instruction boundary reported by the core it looks at fourteen maskable request lines and a non-maskable request built from three gated sources. If something is pending it runs a fixed entry sequence through a single memory port. That sequence stacks the program counter, then the status register, then picks the winning vector, acknowledges it where that is safe, and fetches the handler address from the vector table at the top of the address space. The same engine also performs the return from a handler, reading the status word and then the program counter back from the stack. After reset it loads the start address from the reset vector without saving anything.

The core stalls while `busy_o` is high and takes the new PC, SP and SR from the outputs in the cycle `upd_o` pulses. Memory traffic uses a valid/ready request channel. Once `mem_valid_o` is raised, address, write flag and write data stay fixed until the cycle in which `mem_ready_i` is high. That cycle completes the access, and for a read `mem_rdata_i` must carry the word in that same cycle. A low `mem_ready_i` stretches the sequence by one cycle per cycle of delay and has no other effect.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset is released, `busy_o` stays high for exactly 4 cycles. In that time one read is made at 0xFFFE, and `upd_o` pulses in the last of those cycles with PC = read word with bit 0 cleared, SR = 0 and SP = `sp_i` with bit 0 cleared. No write is made.
- R2: Vector k (0..15) lives at address 0xFFE0 + 2k. Among accepted requests the highest index wins. Maskable line `irq_i[k]` is vector k, the non-maskable request is vector 14 and reset is vector 15. The loaded PC is the fetched word with bit 0 cleared.
- R3: Maskable requests are accepted only when SR bit 3 (global enable) is 1. With it at 0 a pending maskable line starts no sequence and causes no memory access.
- R4: The non-maskable request is active when any of the three `nmi_src_i` bits is set together with the matching `nmi_en_i` bit. It ignores SR bit 3 and beats every maskable line. Its entry pulses `nmi_disarm_o` for exactly one cycle. A source whose enable is 0 starts nothing.
- R5: Entry writes the PC to SP−2 and then the SR to SP−4, in that order, where SP is `sp_i` with bit 0 cleared.
- R6: After entry, SR equals the old SR with every bit cleared except bit 6, and SP equals SP−4.
- R7: When the winner is a maskable vector whose bit is set in `SINGLE_SRC` (default 14'h1555, so even indices), `irq_ack_o` carries that single bit for one cycle. A winner whose bit is clear gets no acknowledge.
- R8: With `mem_ready_i` held high, entry keeps `busy_o` high for 6 cycles and return for 5 cycles. `upd_o` pulses in the last busy cycle.
- R9: Requests are sampled only in a cycle with `inst_boundary_i` high. Pending requests without a boundary start nothing.
- R10: Return (`reti_i` with the boundary) reads SR from SP, then PC from SP+2, and loads SR = first word, PC = second word with bit 0 cleared and SP = SP+4. A return request beats any pending interrupt at the same boundary.
- R11: While `mem_valid_o` is high and `mem_ready_i` is low, address, write flag and write data stay unchanged. Each stalled cycle adds one busy cycle.
- R12: The winner is decided again in the fourth cycle of entry. A higher-index request that arrives after the boundary but by that cycle takes the vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, starts the reset vector load on release |
| inst_boundary_i | input | 1 | Core is between instructions; requests sampled |
| reti_i | input | 1 | Core asks for a return from handler (with boundary) |
| irq_i | input | N_MASK | Maskable request lines, bit k is vector k |
| nmi_src_i | input | N_NMI | Non-maskable source flags |
| nmi_en_i | input | N_NMI | Per-source enables for the non-maskable request |
| pc_i | input | W | Current program counter |
| sp_i | input | W | Current stack pointer |
| sr_i | input | W | Current status register |
| busy_o | output | 1 | Sequence running; core must stall |
| upd_o | output | 1 | One-cycle strobe: core loads pc_o, sp_o, sr_o |
| pc_o | output | W | New program counter |
| sp_o | output | W | New stack pointer |
| sr_o | output | W | New status register |
| irq_ack_o | output | N_MASK | One-cycle clear strobe for an accepted single-source line |
| nmi_disarm_o | output | 1 | One-cycle strobe clearing all non-maskable source enables |
| mem_valid_o | output | 1 | Memory request valid |
| mem_ready_i | input | 1 | Memory accepts request this cycle |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | W | Byte address of the word |
| mem_wdata_o | output | W | Write data |
| mem_rdata_i | input | W | Read data, valid in the accepting cycle |

## Verification
The properties rely on the memory returning read data in the accepting cycle and on `mem_ready_i` rising within a bounded time. They also take the status register to be meaningful only while the block is idle, because the block captures it at the boundary. The stimulus changes every input one nanosecond after a rising edge and holds PC, SP and SR steady during a sequence. It delays memory acceptance by at most two cycles per access, and it clears request lines only once the block has returned to idle, so the protocol those properties depend on is never broken.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  // Status register bit positions the sequencer interprets.
  localparam int SR_GIE_BIT  = 3;
  localparam int SR_SCG0_BIT = 6;

  // One state per cycle of each sequence (entry 6, return 5, reset 4).
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_E_START,
    ST_E_PUSH_PC,
    ST_E_PUSH_SR,
    ST_E_SELECT,
    ST_E_VEC,
    ST_E_LOAD,
    ST_X_START,
    ST_X_POP_SR,
    ST_X_POP_PC,
    ST_X_HOLD,
    ST_X_LOAD,
    ST_R_START,
    ST_R_SETTLE,
    ST_R_VEC,
    ST_R_LOAD
  } seq_state_t;

  function automatic logic is_load_state(seq_state_t s);
    return (s == ST_E_LOAD) || (s == ST_X_LOAD) || (s == ST_R_LOAD);
  endfunction

  function automatic logic is_mem_state(seq_state_t s);
    return (s == ST_E_PUSH_PC) || (s == ST_E_PUSH_SR) || (s == ST_E_VEC) ||
           (s == ST_X_POP_SR) || (s == ST_X_POP_PC) || (s == ST_R_VEC);
  endfunction

endpackage

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
  parameter int N_MASK = 14,
  localparam int IW    = $clog2(N_MASK + 2)
) (
  input  logic [N_MASK-1:0] irq_i,
  input  logic              gie_i,
  input  logic              nmi_i,
  output logic              any_o,
  output logic [IW-1:0]     idx_o
);

  // Index N_MASK is the non-maskable request; it bypasses the enable.
  logic [N_MASK:0] req_all;

  for (genvar g = 0; g < N_MASK; g++) begin : g_gate
    assign req_all[g] = irq_i[g] & gie_i;
  end
  assign req_all[N_MASK] = nmi_i;

  assign any_o = |req_all;

  // Highest index wins: later hits override earlier ones.
  always_comb begin
    idx_o = '0;
    for (int i = 0; i <= N_MASK; i++) begin
      if (req_all[i]) idx_o = IW'(i);
    end
  end

endmodule

// File: rtl/irq_mem_port.sv
module irq_mem_port
  import irq_seq_pkg::*;
#(
  parameter int W      = 16,
  parameter int N_MASK = 14,
  localparam int IW    = $clog2(N_MASK + 2),
  localparam int RST_IDX = N_MASK + 1,
  localparam logic [W-1:0] VEC_BASE = {W{1'b1}} - W'(2 * (N_MASK + 2) - 1)
) (
  input  seq_state_t     state_i,
  input  logic [W-1:0]   sp_base_i,
  input  logic [W-1:0]   pc_lat_i,
  input  logic [W-1:0]   sr_lat_i,
  input  logic [IW-1:0]  win_idx_i,
  output logic           mem_valid_o,
  output logic           mem_we_o,
  output logic [W-1:0]   mem_addr_o,
  output logic [W-1:0]   mem_wdata_o
);

  // Everything here depends only on state and latched values, so the
  // request stays fixed while the memory holds ready low.
  always_comb begin
    mem_valid_o = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    case (state_i)
      ST_E_PUSH_PC: begin
        mem_valid_o = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = sp_base_i - W'(2);
        mem_wdata_o = pc_lat_i;
      end
      ST_E_PUSH_SR: begin
        mem_valid_o = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = sp_base_i - W'(4);
        mem_wdata_o = sr_lat_i;
      end
      ST_E_VEC: begin
        mem_valid_o = 1'b1;
        mem_addr_o  = VEC_BASE + W'({win_idx_i, 1'b0});
      end
      ST_X_POP_SR: begin
        mem_valid_o = 1'b1;
        mem_addr_o  = sp_base_i;
      end
      ST_X_POP_PC: begin
        mem_valid_o = 1'b1;
        mem_addr_o  = sp_base_i + W'(2);
      end
      ST_R_VEC: begin
        mem_valid_o = 1'b1;
        mem_addr_o  = VEC_BASE + W'(2 * RST_IDX);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
#(
  parameter int W      = 16,
  parameter int N_MASK = 14,
  parameter logic [N_MASK-1:0] SINGLE_SRC = '0,
  localparam int IW    = $clog2(N_MASK + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inst_boundary_i,
  input  logic              reti_i,
  input  logic [W-1:0]      pc_i,
  input  logic [W-1:0]      sp_i,
  input  logic [W-1:0]      sr_i,
  input  logic              arb_any_i,
  input  logic [IW-1:0]     arb_idx_i,
  input  logic              mem_ready_i,
  input  logic [W-1:0]      mem_rdata_i,
  output seq_state_t        state_o,
  output logic              arb_gie_o,
  output logic [W-1:0]      pc_lat_o,
  output logic [W-1:0]      sp_lat_o,
  output logic [W-1:0]      sr_lat_o,
  output logic [IW-1:0]     win_idx_o,
  output logic [N_MASK-1:0] irq_ack_o,
  output logic              nmi_disarm_o,
  output logic              busy_o,
  output logic              upd_o,
  output logic [W-1:0]      pc_o,
  output logic [W-1:0]      sp_o,
  output logic [W-1:0]      sr_o
);

  localparam logic [W-1:0] SR_KEEP  = W'(1) << SR_SCG0_BIT;
  localparam logic [W-1:0] EVEN_MSK = ~W'(1);
  localparam logic [IW-1:0] NMI_IDX = IW'(N_MASK);

  seq_state_t st, st_nxt;
  logic [IW-1:0] win_q;
  logic [IW-1:0] sel_idx;
  logic          in_sel;
  logic          step_ok;

  assign state_o   = st;
  assign busy_o    = (st != ST_IDLE);
  assign upd_o     = is_load_state(st);
  assign win_idx_o = win_q;

  // The enable seen by the arbiter: live while idle, captured afterwards.
  assign arb_gie_o = (st == ST_IDLE) ? sr_i[SR_GIE_BIT] : sr_lat_o[SR_GIE_BIT];

  // Select step: a live winner overrides the one captured at the boundary.
  assign in_sel  = (st == ST_E_SELECT);
  assign sel_idx = arb_any_i ? arb_idx_i : win_q;

  for (genvar g = 0; g < N_MASK; g++) begin : g_ack
    if (SINGLE_SRC[g]) begin : g_single
      assign irq_ack_o[g] = in_sel && (sel_idx == IW'(g));
    end else begin : g_multi
      assign irq_ack_o[g] = 1'b0;
    end
  end
  assign nmi_disarm_o = in_sel && (sel_idx == NMI_IDX);

  // Memory states advance only on acceptance.
  assign step_ok = !is_mem_state(st) || mem_ready_i;

  always_comb begin
    st_nxt = st;
    case (st)
      ST_IDLE: begin
        if (inst_boundary_i) begin
          if (reti_i)         st_nxt = ST_X_START;
          else if (arb_any_i) st_nxt = ST_E_START;
        end
      end
      ST_E_START:   st_nxt = ST_E_PUSH_PC;
      ST_E_PUSH_PC: if (step_ok) st_nxt = ST_E_PUSH_SR;
      ST_E_PUSH_SR: if (step_ok) st_nxt = ST_E_SELECT;
      ST_E_SELECT:  st_nxt = ST_E_VEC;
      ST_E_VEC:     if (step_ok) st_nxt = ST_E_LOAD;
      ST_E_LOAD:    st_nxt = ST_IDLE;
      ST_X_START:   st_nxt = ST_X_POP_SR;
      ST_X_POP_SR:  if (step_ok) st_nxt = ST_X_POP_PC;
      ST_X_POP_PC:  if (step_ok) st_nxt = ST_X_HOLD;
      ST_X_HOLD:    st_nxt = ST_X_LOAD;
      ST_X_LOAD:    st_nxt = ST_IDLE;
      ST_R_START:   st_nxt = ST_R_SETTLE;
      ST_R_SETTLE:  st_nxt = ST_R_VEC;
      ST_R_VEC:     if (step_ok) st_nxt = ST_R_LOAD;
      ST_R_LOAD:    st_nxt = ST_IDLE;
      default:      st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_R_START;
      pc_lat_o <= '0;
      sp_lat_o <= '0;
      sr_lat_o <= '0;
      win_q    <= '0;
      pc_o     <= '0;
      sp_o     <= '0;
      sr_o     <= '0;
    end else begin
      st <= st_nxt;
      // Core state is tracked while idle; the boundary cycle's value sticks.
      if (st == ST_IDLE || st == ST_R_START) begin
        pc_lat_o <= pc_i;
        sp_lat_o <= sp_i & EVEN_MSK;
        sr_lat_o <= sr_i;
        win_q    <= arb_idx_i;
      end
      if (in_sel) win_q <= sel_idx;
      if (mem_ready_i) begin
        case (st)
          ST_E_VEC: begin
            pc_o <= mem_rdata_i & EVEN_MSK;
            sp_o <= sp_lat_o - W'(4);
            sr_o <= sr_lat_o & SR_KEEP;
          end
          ST_X_POP_SR: sr_o <= mem_rdata_i;
          ST_X_POP_PC: begin
            pc_o <= mem_rdata_i & EVEN_MSK;
            sp_o <= sp_lat_o + W'(4);
          end
          ST_R_VEC: begin
            pc_o <= mem_rdata_i & EVEN_MSK;
            sp_o <= sp_lat_o;
            sr_o <= '0;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int W      = 16,
  parameter int N_MASK = 14,
  parameter int N_NMI  = 3,
  parameter logic [N_MASK-1:0] SINGLE_SRC = 14'h1555,
  localparam int IW    = $clog2(N_MASK + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inst_boundary_i,
  input  logic              reti_i,
  input  logic [N_MASK-1:0] irq_i,
  input  logic [N_NMI-1:0]  nmi_src_i,
  input  logic [N_NMI-1:0]  nmi_en_i,
  input  logic [W-1:0]      pc_i,
  input  logic [W-1:0]      sp_i,
  input  logic [W-1:0]      sr_i,
  output logic              busy_o,
  output logic              upd_o,
  output logic [W-1:0]      pc_o,
  output logic [W-1:0]      sp_o,
  output logic [W-1:0]      sr_o,
  output logic [N_MASK-1:0] irq_ack_o,
  output logic              nmi_disarm_o,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic              mem_we_o,
  output logic [W-1:0]      mem_addr_o,
  output logic [W-1:0]      mem_wdata_o,
  input  logic [W-1:0]      mem_rdata_i
);

  seq_state_t    state;
  logic          arb_gie;
  logic          arb_any;
  logic [IW-1:0] arb_idx;
  logic [IW-1:0] win_idx;
  logic [W-1:0]  pc_lat, sp_lat, sr_lat;
  logic          nmi_act;

  assign nmi_act = |(nmi_src_i & nmi_en_i);

  irq_prio_arb #(.N_MASK(N_MASK)) arb_i (
    .irq_i (irq_i),
    .gie_i (arb_gie),
    .nmi_i (nmi_act),
    .any_o (arb_any),
    .idx_o (arb_idx)
  );

  irq_seq_ctrl #(.W(W), .N_MASK(N_MASK), .SINGLE_SRC(SINGLE_SRC)) ctrl_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .inst_boundary_i (inst_boundary_i),
    .reti_i          (reti_i),
    .pc_i            (pc_i),
    .sp_i            (sp_i),
    .sr_i            (sr_i),
    .arb_any_i       (arb_any),
    .arb_idx_i       (arb_idx),
    .mem_ready_i     (mem_ready_i),
    .mem_rdata_i     (mem_rdata_i),
    .state_o         (state),
    .arb_gie_o       (arb_gie),
    .pc_lat_o        (pc_lat),
    .sp_lat_o        (sp_lat),
    .sr_lat_o        (sr_lat),
    .win_idx_o       (win_idx),
    .irq_ack_o       (irq_ack_o),
    .nmi_disarm_o    (nmi_disarm_o),
    .busy_o          (busy_o),
    .upd_o           (upd_o),
    .pc_o            (pc_o),
    .sp_o            (sp_o),
    .sr_o            (sr_o)
  );

  irq_mem_port #(.W(W), .N_MASK(N_MASK)) mem_i (
    .state_i     (state),
    .sp_base_i   (sp_lat),
    .pc_lat_i    (pc_lat),
    .sr_lat_i    (sr_lat),
    .win_idx_i   (win_idx),
    .mem_valid_o (mem_valid_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o)
  );

endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk
  import irq_seq_pkg::*;
#(
  parameter int W      = 16,
  parameter int N_MASK = 14,
  parameter int N_NMI  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              inst_boundary_i,
  input logic              reti_i,
  input logic [N_NMI-1:0]  nmi_src_i,
  input logic [N_NMI-1:0]  nmi_en_i,
  input logic [W-1:0]      sr_i,
  input logic              busy_o,
  input logic              upd_o,
  input logic [N_MASK-1:0] irq_ack_o,
  input logic              nmi_disarm_o,
  input logic              mem_valid_o,
  input logic              mem_ready_i,
  input logic              mem_we_o,
  input logic [W-1:0]      mem_addr_o,
  input logic [W-1:0]      mem_wdata_o
);

  a_r11_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o) &&
                                    $stable(mem_we_o) && $stable(mem_wdata_o));

  a_r11_valid_in_seq: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid_o |-> busy_o);

  a_r7_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_ack_o));

  a_r7_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_ack_o) |=> (irq_ack_o == '0));

  a_r4_disarm_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_disarm_o |=> !nmi_disarm_o);

  a_r3_gie_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && inst_boundary_i && !reti_i && !(|(nmi_src_i & nmi_en_i)) &&
    !sr_i[SR_GIE_BIT] |=> !busy_o);

  a_r9_boundary_only: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && !inst_boundary_i |=> !busy_o);

  a_r8_update_ends: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |=> !busy_o);

endmodule

bind irq_entry_seq irq_entry_seq_chk #(.W(W), .N_MASK(N_MASK), .N_NMI(N_NMI)) chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .inst_boundary_i (inst_boundary_i),
  .reti_i          (reti_i),
  .nmi_src_i       (nmi_src_i),
  .nmi_en_i        (nmi_en_i),
  .sr_i            (sr_i),
  .busy_o          (busy_o),
  .upd_o           (upd_o),
  .irq_ack_o       (irq_ack_o),
  .nmi_disarm_o    (nmi_disarm_o),
  .mem_valid_o     (mem_valid_o),
  .mem_ready_i     (mem_ready_i),
  .mem_we_o        (mem_we_o),
  .mem_addr_o      (mem_addr_o),
  .mem_wdata_o     (mem_wdata_o)
);

// File: tb/irq_entry_seq_tb_top.sv
module irq_entry_seq_tb_top;

  localparam int NM = 14;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          inst_boundary = 1'b0;
  logic          reti = 1'b0;
  logic [NM-1:0] irq = '0;
  logic [2:0]    nmi_src = '0;
  logic [2:0]    nmi_en = '0;
  logic [15:0]   pc_in = '0, sp_in = '0, sr_in = '0;
  logic          busy_o, upd_o, nmi_disarm_o;
  logic [15:0]   pc_o, sp_o, sr_o;
  logic [NM-1:0] irq_ack_o;
  logic          mem_valid_o, mem_we_o;
  logic          mem_ready = 1'b1;
  logic [15:0]   mem_addr_o, mem_wdata_o, mem_rdata;

  irq_entry_seq dut_i (
    .clk(clk), .rst_n(rst_n), .inst_boundary_i(inst_boundary), .reti_i(reti),
    .irq_i(irq), .nmi_src_i(nmi_src), .nmi_en_i(nmi_en),
    .pc_i(pc_in), .sp_i(sp_in), .sr_i(sr_in),
    .busy_o(busy_o), .upd_o(upd_o), .pc_o(pc_o), .sp_o(sp_o), .sr_o(sr_o),
    .irq_ack_o(irq_ack_o), .nmi_disarm_o(nmi_disarm_o),
    .mem_valid_o(mem_valid_o), .mem_ready_i(mem_ready), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Memory model: vector table words and a two-word stack frame.
  logic [15:0] stk_base = 16'h0100, stk_sr = '0, stk_pc = '0;

  function automatic logic [15:0] vec_word(int k);
    return 16'h8001 + 16'(k * 258);
  endfunction

  always_comb begin
    if (mem_addr_o == stk_base)              mem_rdata = stk_sr;
    else if (mem_addr_o == stk_base + 16'd2) mem_rdata = stk_pc;
    else if (mem_addr_o >= 16'hFFE0)         mem_rdata = vec_word(int'((mem_addr_o - 16'hFFE0) >> 1));
    else                                     mem_rdata = 16'hDEAD;
  end

  // Ready driver and observation log, both away from the active edge.
  bit          stall_en = 1'b0;
  int          wc = 0;
  int          busy_cnt, upd_cnt, ack_cnt, dis_cnt, n_acc;
  logic [NM-1:0] ack_last;
  logic [15:0] acc_addr [8];
  logic [15:0] acc_data [8];
  logic        acc_we   [8];

  always @(negedge clk) begin
    if (!stall_en) mem_ready = 1'b1;
    else if (mem_valid_o && wc < 2) begin mem_ready = 1'b0; wc++; end
    else begin mem_ready = 1'b1; wc = 0; end
    if (busy_o) busy_cnt++;
    if (upd_o) upd_cnt++;
    if (|irq_ack_o) begin ack_cnt++; ack_last = irq_ack_o; end
    if (nmi_disarm_o) dis_cnt++;
    if (mem_valid_o && mem_ready) begin
      if (n_acc < 8) begin
        acc_addr[n_acc] = mem_addr_o;
        acc_data[n_acc] = mem_wdata_o;
        acc_we[n_acc]   = mem_we_o;
      end
      n_acc++;
    end
  end

  task automatic clear_log;
    busy_cnt = 0; upd_cnt = 0; ack_cnt = 0; dis_cnt = 0; n_acc = 0; ack_last = '0;
  endtask

  task automatic step;
    @(posedge clk); #1;
  endtask

  task automatic boundary(input logic ret);
    step;
    inst_boundary = 1'b1; reti = ret;
    step;
    inst_boundary = 1'b0; reti = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!busy_o) break;
    end
    chk(req, busy_o, 1'b0);
    step;
  endtask

  task automatic t_reset;
    sp_in = 16'h0400;
    rst_n = 1'b0;
    repeat (3) step;
    rst_n = 1'b1;
    clear_log;
    wait_idle("R1 idle");
    chk("R1 busy cycles", busy_cnt, 4);
    chk("R1 accesses", n_acc, 1);
    chk("R1 vector addr", acc_addr[0], 16'hFFFE);
    chk("R1 read", acc_we[0], 1'b0);
    chk("R1 update pulses", upd_cnt, 1);
    chk("R1 pc", pc_o, vec_word(15) & 16'hFFFE);
    chk("R1 sr", sr_o, 16'h0000);
    chk("R1 sp", sp_o, 16'h0400);
  endtask

  task automatic t_entry_multi(input bit stall);
    stall_en = stall;
    sr_in = 16'h01F9; pc_in = 16'h1234; sp_in = 16'h0A01;
    irq = '0; irq[3] = 1'b1; irq[9] = 1'b1;
    clear_log;
    boundary(1'b0);
    wait_idle("R8 idle");
    irq = '0;
    stall_en = 1'b0;
    if (stall) chk("R11 stretched busy", busy_cnt, 12);
    else       chk("R8 entry busy", busy_cnt, 6);
    chk("R8 update pulses", upd_cnt, 1);
    chk("R5 accesses", n_acc, 3);
    chk("R5 pc push addr", acc_addr[0], 16'h09FE);
    chk("R5 pc push we", acc_we[0], 1'b1);
    chk("R5 pc push data", acc_data[0], 16'h1234);
    chk("R5 sr push addr", acc_addr[1], 16'h09FC);
    chk("R5 sr push data", acc_data[1], 16'h01F9);
    chk("R2 vector addr", acc_addr[2], 16'hFFF2);
    chk("R2 vector read", acc_we[2], 1'b0);
    chk("R2 pc", pc_o, vec_word(9) & 16'hFFFE);
    chk("R6 sp", sp_o, 16'h09FC);
    chk("R6 sr", sr_o, 16'h0040);
    chk("R7 multi-source no ack", ack_cnt, 0);
    chk("R4 no disarm", dis_cnt, 0);
  endtask

  task automatic t_entry_single;
    sr_in = 16'h0008; pc_in = 16'h2000; sp_in = 16'h0800;
    irq = '0; irq[2] = 1'b1; irq[4] = 1'b1;
    clear_log;
    boundary(1'b0);
    wait_idle("R7 idle");
    irq = '0;
    chk("R2 vector addr", acc_addr[2], 16'hFFE8);
    chk("R7 ack count", ack_cnt, 1);
    chk("R7 ack bit", ack_last, 14'h0010);
    chk("R6 sr", sr_o, 16'h0000);
  endtask

  task automatic t_gie_off;
    sr_in = 16'h0040;
    irq = '0; irq[13] = 1'b1;
    clear_log;
    boundary(1'b0);
    repeat (5) step;
    irq = '0;
    chk("R3 no sequence", busy_cnt, 0);
    chk("R3 no access", n_acc, 0);
  endtask

  task automatic t_nmi;
    sr_in = 16'h0000; pc_in = 16'h3000; sp_in = 16'h0900;
    irq = '0; irq[13] = 1'b1;
    nmi_src = 3'b010; nmi_en = 3'b010;
    clear_log;
    boundary(1'b0);
    wait_idle("R4 idle");
    chk("R4 busy", busy_cnt, 6);
    chk("R4 vector addr", acc_addr[2], 16'hFFFC);
    chk("R4 disarm pulses", dis_cnt, 1);
    chk("R4 no maskable ack", ack_cnt, 0);
    chk("R4 pc", pc_o, vec_word(14) & 16'hFFFE);
    nmi_src = 3'b001; nmi_en = 3'b110;
    clear_log;
    boundary(1'b0);
    repeat (5) step;
    chk("R4 disabled source ignored", busy_cnt, 0);
    nmi_src = '0; nmi_en = '0; irq = '0;
  endtask

  task automatic t_no_boundary;
    sr_in = 16'h0008;
    irq = '0; irq[7] = 1'b1;
    clear_log;
    repeat (10) step;
    irq = '0;
    chk("R9 no sequence", busy_cnt, 0);
    chk("R9 no access", n_acc, 0);
  endtask

  task automatic t_return;
    sr_in = 16'h0008; pc_in = 16'h4000; sp_in = 16'h09FC;
    stk_base = 16'h09FC; stk_sr = 16'h0018; stk_pc = 16'h2345;
    irq = '0; irq[5] = 1'b1;
    clear_log;
    boundary(1'b1);
    wait_idle("R10 idle");
    irq = '0;
    chk("R8 return busy", busy_cnt, 5);
    chk("R10 accesses", n_acc, 2);
    chk("R10 sr pop addr", acc_addr[0], 16'h09FC);
    chk("R10 pc pop addr", acc_addr[1], 16'h09FE);
    chk("R10 reads", {acc_we[0], acc_we[1]}, 2'b00);
    chk("R10 sr", sr_o, 16'h0018);
    chk("R10 pc", pc_o, 16'h2344);
    chk("R10 sp", sp_o, 16'h0A00);
    chk("R10 return beats request", ack_cnt, 0);
    stk_base = 16'h0100;
  endtask

  task automatic t_late;
    sr_in = 16'h0008; pc_in = 16'h5000; sp_in = 16'h0800;
    irq = '0; irq[1] = 1'b1;
    clear_log;
    boundary(1'b0);
    step;
    irq[11] = 1'b1;
    wait_idle("R12 idle");
    irq = '0;
    chk("R12 late winner addr", acc_addr[2], 16'hFFF6);
    chk("R12 pc", pc_o, vec_word(11) & 16'hFFFE);
    chk("R12 no ack", ack_cnt, 0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R8 actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    clear_log;
    t_reset;
    t_entry_multi(1'b0);
    t_entry_single;
    t_gie_off;
    t_nmi;
    t_no_boundary;
    t_return;
    t_entry_multi(1'b1);
    t_late;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule